// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 64 by 64 sprite cursor over a raster scan. Each cycle it takes the current pixel column and row from a timing generator together with the underlying display pixel, decides whether that pixel falls inside the visible cursor window, and, if so, reads the cursor image and mixes it with the display pixel. The image is held in an external 1024-byte memory with a synchronous read port. Each image pixel carries a two-bit code that selects one of two programmed colours, the display pixel unchanged, or the display pixel inverted.

The window is placed by a position word and trimmed by an offset word. The horizontal offset hides image columns on the left. The vertical offset shortens the window from the bottom. To hide lines at the top, software moves the image start address, which is given in 8-byte units. A doublescan flag doubles the window's vertical placement and repeats each image line on two raster lines. While the enable input is low, every pixel passes through.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, outRgb is 0 whatever dispRgb holds.
- R2: When curEnable was low in the cycle a pixel was presented, outRgb one cycle later equals that dispRgb.
- R3: Inside the window the image code selects the output: 00 gives colour 0, 01 gives colour 1, 10 gives the display pixel, 11 gives the bitwise complement of the display pixel.
- R4: In each image byte, the leftmost of its four pixels uses bits 1:0, and the following pixels use bits 3:2, 5:4 and 7:6 in turn.
- R5: With posX = curPos[15:0] and hOff = curOff[15:0], the window covers screen columns posX to posX+63-hOff and shows image columns hOff to 63. If hOff is 64 or more, no column is covered. Pixels outside the window pass through.
- R6: With posY = curPos[31:16] and vOff = curOff[31:16], the window covers 64-vOff raster lines starting at row posY, showing image line 0 first. If vOff is 64 or more, no line is covered.
- R7: memAddr equals (curBase*8 + line*16 + column/4) modulo 1024 during the same cycle as the pixel coordinates, where line and column are the image line and column being shown.
- R8: With dblScan high, the window starts at row 2*posY, covers 2*(64-vOff) lines, and each image line appears on two consecutive raster lines.
- R9: A colour register supplies red in bits 31:24, green in 23:16 and blue in 15:8, which appear on outRgb[23:16], [15:8] and [7:0]. Bits 7:0 of the register have no effect.
- R10: outRgb changes only at a clock edge. It reflects the pixel presented in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixX | input | 16 | Current raster column |
| pixY | input | 16 | Current raster row |
| dispRgb | input | 24 | Underlying display pixel |
| curEnable | input | 1 | Overlay enable |
| dblScan | input | 1 | Doublescan raster active |
| curPos | input | 32 | Window row in 31:16, column in 15:0 |
| curOff | input | 32 | Vertical offset in 31:16, horizontal offset in 15:0 |
| curBase | input | 7 | Image start address in 8-byte units |
| curColor0 | input | 32 | Colour selected by code 00 |
| curColor1 | input | 32 | Colour selected by code 01 |
| memAddr | output | 10 | Image memory byte address |
| memRdData | input | 8 | Image byte, returned one cycle after memAddr |
| outRgb | output | 24 | Final pixel |

## Verification
The horizontal and vertical window tests can reach their limits in the same cycle. The case that matters is a pixel on the last shown column and the last shown line, where both compares must hold together, along with the pixels just past each edge. The bench places pixels exactly on these corners, both with plain and with doubled line placement. It judges each output against a model built from the requirements. In the same cycle the address must also wrap correctly when the start address is near the top of memory, and the bench checks memAddr directly in the cycle the coordinates are presented.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
  typedef struct packed {
    logic       hit;
    logic [1:0] pairSel;
  } cur_strobe_t;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_overlay_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 10,
  parameter int IMG_DIM = 64
) (
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [COORD_W-1:0] hOff,
  input  logic [COORD_W-1:0] vOff,
  input  logic               dblScan,
  input  logic               enable,
  input  logic [ADDR_W-4:0]  base,
  output logic [ADDR_W-1:0]  memAddr,
  output cur_strobe_t        strobe
);
  localparam int W        = COORD_W + 2;
  localparam int IDX_W    = $clog2(IMG_DIM);
  localparam int LINE_B   = IMG_DIM / 4;
  localparam int LINE_SH  = $clog2(LINE_B);
  localparam int SUM_W    = ADDR_W + IDX_W + 1;
  localparam logic [W-1:0] DIM_W = W'(IMG_DIM);

  logic [W-1:0] dx, dy, effY, widthX, lines, heightY;
  logic         hitX, hitY;
  logic [IDX_W-1:0] col, line;
  logic [SUM_W-1:0] sum;

  always_comb begin
    dx     = {2'b00, pixX} - {2'b00, posX};
    widthX = ({2'b00, hOff} < DIM_W) ? DIM_W - {2'b00, hOff} : '0;
    hitX   = (pixX >= posX) && (dx < widthX);
    col    = hOff[IDX_W-1:0] + dx[IDX_W-1:0];

    effY    = dblScan ? {1'b0, posY, 1'b0} : {2'b00, posY};
    dy      = {2'b00, pixY} - effY;
    lines   = ({2'b00, vOff} < DIM_W) ? DIM_W - {2'b00, vOff} : '0;
    heightY = dblScan ? {lines[W-2:0], 1'b0} : lines;
    hitY    = ({2'b00, pixY} >= effY) && (dy < heightY);
    line    = dblScan ? dy[IDX_W:1] : dy[IDX_W-1:0];

    sum = SUM_W'({base, 3'b000})
        + (SUM_W'(line) << LINE_SH)
        + SUM_W'(col[IDX_W-1:2]);
    memAddr = sum[ADDR_W-1:0];

    strobe.hit     = enable && hitX && hitY;
    strobe.pairSel = col[1:0];
  end
endmodule

// File: rtl/cursor_dp.sv
module cursor_dp
  import cursor_overlay_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cur_strobe_t      strobe,
  input  logic [RGB_W-1:0] dispRgb,
  input  logic [RGB_W-1:0] color0,
  input  logic [RGB_W-1:0] color1,
  input  logic [7:0]       memRdData,
  output logic [RGB_W-1:0] outRgb
);
  cur_strobe_t      strobeQ;
  logic [RGB_W-1:0] dispQ, col0Q, col1Q;
  logic [1:0]       code;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= '0;
      dispQ   <= '0;
      col0Q   <= '0;
      col1Q   <= '0;
    end else begin
      strobeQ <= strobe;
      dispQ   <= dispRgb;
      col0Q   <= color0;
      col1Q   <= color1;
    end
  end

  always_comb begin
    code = memRdData[{strobeQ.pairSel, 1'b0} +: 2];
    if (!strobeQ.hit) begin
      outRgb = dispQ;
    end else begin
      unique case (code)
        2'b00:   outRgb = col0Q;
        2'b01:   outRgb = col1Q;
        2'b10:   outRgb = dispQ;
        default: outRgb = ~dispQ;
      endcase
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int IMG_DIM = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       pixX,
  input  logic [15:0]       pixY,
  input  logic [23:0]       dispRgb,
  input  logic              curEnable,
  input  logic              dblScan,
  input  logic [31:0]       curPos,
  input  logic [31:0]       curOff,
  input  logic [ADDR_W-4:0] curBase,
  input  logic [31:0]       curColor0,
  input  logic [31:0]       curColor1,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic [23:0]       outRgb
);
  cur_strobe_t strobe;
  logic unusedColorBits;
  assign unusedColorBits = ^{curColor0[7:0], curColor1[7:0]};

  cursor_ctrl #(.COORD_W(16), .ADDR_W(ADDR_W), .IMG_DIM(IMG_DIM)) ctrl (
    .pixX(pixX), .pixY(pixY),
    .posX(curPos[15:0]), .posY(curPos[31:16]),
    .hOff(curOff[15:0]), .vOff(curOff[31:16]),
    .dblScan(dblScan), .enable(curEnable), .base(curBase),
    .memAddr(memAddr), .strobe(strobe)
  );

  cursor_dp #(.RGB_W(24)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dispRgb(dispRgb),
    .color0(curColor0[31:8]), .color1(curColor1[31:8]),
    .memRdData(memRdData), .outRgb(outRgb)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int IMG_DIM = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] pixX,
  input logic [23:0] dispRgb,
  input logic        curEnable,
  input logic [31:0] curPos,
  input logic [31:0] curOff,
  input logic [31:0] curColor0,
  input logic [31:0] curColor1,
  input logic [23:0] outRgb
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r2_disabled_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(curEnable)) |-> (outRgb == $past(dispRgb)));

  a_r5_left_of_window: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ($past(pixX) < $past(curPos[15:0]))) |-> (outRgb == $past(dispRgb)));

  a_r5_hoff_hides_all: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ($past(curOff[15:0]) >= 16'(IMG_DIM))) |-> (outRgb == $past(dispRgb)));

  a_r3_output_choice: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((outRgb == $past(dispRgb)) || (outRgb == ~$past(dispRgb)) ||
                   (outRgb == $past(curColor0[31:8])) || (outRgb == $past(curColor1[31:8]))));
endmodule

bind cursor_overlay cursor_overlay_chk #(.IMG_DIM(IMG_DIM)) chk (
  .clk(clk), .rstN(rstN), .pixX(pixX), .dispRgb(dispRgb), .curEnable(curEnable),
  .curPos(curPos), .curOff(curOff), .curColor0(curColor0), .curColor1(curColor1),
  .outRgb(outRgb)
);

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] pixX, pixY;
  logic [23:0] dispRgb;
  logic        curEnable, dblScan;
  logic [31:0] curPos, curOff, curColor0, curColor1;
  logic [6:0]  curBase;
  logic [9:0]  memAddr;
  logic [7:0]  memRdData;
  logic [23:0] outRgb;

  logic [7:0] mem [1024];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) memRdData <= mem[memAddr];

  cursor_overlay uut (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY), .dispRgb(dispRgb),
    .curEnable(curEnable), .dblScan(dblScan), .curPos(curPos), .curOff(curOff),
    .curBase(curBase), .curColor0(curColor0), .curColor1(curColor1),
    .memAddr(memAddr), .memRdData(memRdData), .outRgb(outRgb)
  );

  // Window-test table: x, y, display pixel; posX=100 posY=50 hOff=4 vOff=8 base=5.
  localparam logic [55:0] VEC [12] = '{
    {16'd100, 16'd50,  24'h123456}, {16'd99,  16'd50,  24'h0F0F0F},
    {16'd159, 16'd50,  24'hA5A5A5}, {16'd160, 16'd50,  24'h5A5A5A},
    {16'd100, 16'd49,  24'h777777}, {16'd100, 16'd105, 24'h313131},
    {16'd100, 16'd106, 24'h424242}, {16'd159, 16'd105, 24'hC0FFEE},
    {16'd160, 16'd106, 24'h00FF00}, {16'd130, 16'd77,  24'hFF0000},
    {16'd101, 16'd51,  24'h0000FF}, {16'd158, 16'd104, 24'h808080}
  };

  function automatic int expAddr(int x, int y);
    int px = curPos[15:0], py = curPos[31:16];
    int ey = dblScan ? 2 * py : py;
    int col = curOff[15:0] + x - px;
    int line = dblScan ? (y - ey) / 2 : (y - ey);
    return (curBase * 8 + line * 16 + col / 4) % 1024;
  endfunction

  function automatic logic [23:0] expRgb(int x, int y, logic [23:0] rgb);
    int px = curPos[15:0], py = curPos[31:16];
    int ho = curOff[15:0], vo = curOff[31:16];
    int ey = dblScan ? 2 * py : py;
    int w = (ho < 64) ? 64 - ho : 0;
    int h = ((vo < 64) ? 64 - vo : 0) * (dblScan ? 2 : 1);
    int col;
    logic [1:0] code;
    if (!curEnable || x < px || x - px >= w || y < ey || y - ey >= h) return rgb;
    col = ho + x - px;
    code = 2'((mem[expAddr(x, y)] >> (2 * (col % 4))) & 8'h3);
    case (code)
      2'b00: return curColor0[31:8];
      2'b01: return curColor1[31:8];
      2'b10: return rgb;
      default: return ~rgb;
    endcase
  endfunction

  task automatic check(logic [23:0] got, logic [23:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic present(int x, int y, logic [23:0] rgb);
    @(negedge clk);
    pixX = 16'(x); pixY = 16'(y); dispRgb = rgb;
    @(posedge clk);
    #1;
  endtask

  task automatic probe(int x, int y, logic [23:0] rgb, string tag);
    logic [23:0] e;
    @(negedge clk);
    pixX = 16'(x); pixY = 16'(y); dispRgb = rgb;
    e = expRgb(x, y, rgb);
    @(posedge clk);
    #1;
    check(outRgb, e, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + (i >> 3) * 11 + 3) & 255);
    rstN = 1'b0; pixX = 0; pixY = 0; dispRgb = 24'hABCDEF;
    curEnable = 1'b1; dblScan = 1'b0; curPos = 0; curOff = 0; curBase = 0;
    curColor0 = 32'h11223344; curColor1 = 32'hEEDDCCBB;
    repeat (3) @(posedge clk);
    #1;
    check(outRgb, 24'h000000, "R1 reset output");
    @(negedge clk); rstN = 1'b1;

    // R3 and R4: byte 0 holds codes 00,01,10,11 for pixels 0..3
    mem[0] = 8'b11_10_01_00;
    probe(0, 0, 24'h13579B, "R3 R4 pixel0 code00");
    check(outRgb, 24'h112233, "R3 colour0 explicit");
    probe(1, 0, 24'h13579B, "R3 R4 pixel1 code01");
    check(outRgb, 24'hEEDDCC, "R9 colour1 fields explicit");
    probe(2, 0, 24'h13579B, "R3 R4 pixel2 code10");
    check(outRgb, 24'h13579B, "R3 passthrough explicit");
    probe(3, 0, 24'h13579B, "R3 R4 pixel3 code11");
    check(outRgb, 24'hECA864, "R3 complement explicit");

    // R9: low byte of colour register ignored
    curColor0 = 32'h112233FF;
    probe(0, 0, 24'h13579B, "R9 low byte ignored");
    check(outRgb, 24'h112233, "R9 colour0 low byte ignored");

    // R10: output holds between edges
    @(negedge clk); dispRgb = 24'h000001; #1;
    check(outRgb, 24'h112233, "R10 output registered");

    // Window table: R5 R6
    curPos = {16'd50, 16'd100}; curOff = {16'd8, 16'd4}; curBase = 7'd5;
    for (int i = 0; i < 12; i++) begin
      logic [55:0] v = VEC[i];
      probe(int'(v[55:40]), int'(v[39:24]), v[23:0], "R5 R6 window table");
    end

    // R7: address in same cycle, and wrap
    @(negedge clk); pixX = 16'd130; pixY = 16'd77; #1;
    check(24'(memAddr), 24'(expAddr(130, 77)), "R7 address");
    curBase = 7'd127; curOff = 0;
    @(negedge clk); pixX = 16'd100; pixY = 16'd51; #1;
    check(24'(memAddr), 24'd8, "R7 address wrap");

    // R2: disabled
    curBase = 7'd0; curPos = 0; curEnable = 1'b0;
    probe(3, 0, 24'h246802, "R2 disabled");
    check(outRgb, 24'h246802, "R2 disabled explicit");
    curEnable = 1'b1;

    // R5: hOff >= 64 hides all
    curOff = {16'd0, 16'd64};
    probe(3, 0, 24'h369CF0, "R5 hoff 64");
    check(outRgb, 24'h369CF0, "R5 hoff 64 explicit");

    // R6: vOff = 60 gives 4 lines
    curPos = {16'd10, 16'd20}; curOff = {16'd60, 16'd0};
    probe(25, 13, 24'h010203, "R6 last line");
    probe(25, 14, 24'h010203, "R6 past last line");
    check(outRgb, 24'h010203, "R6 past last line explicit");

    // R8: doublescan
    dblScan = 1'b1; curOff = {16'd62, 16'd0};
    probe(20, 19, 24'h445566, "R8 above window");
    check(outRgb, 24'h445566, "R8 above window explicit");
    probe(20, 20, 24'h445566, "R8 first raster line");
    @(negedge clk); pixX = 16'd20; pixY = 16'd21; #1;
    check(24'(memAddr), 24'd0, "R8 line repeated address");
    @(negedge clk); pixY = 16'd22; #1;
    check(24'(memAddr), 24'd16, "R8 next image line address");
    probe(83, 23, 24'h778899, "R8 corner last column last line");
    probe(83, 24, 24'h778899, "R8 past doubled window");
    probe(84, 23, 24'h778899, "R5 R8 past last column");

    present(0, 0, 24'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule